// File: doc/BRIEF.md
# Hour-Aligned Display Power Scheduler

This block decides when a clock display receives power. It keeps a seconds-of-hour count that a time-update strobe can overwrite and that a 1 Hz tick advances. A four-bit interval code picks a slot length that divides the hour evenly, and a four-bit duration code sets a half-width in seconds. On every tick the block works out whether the current second lies inside a window centred on a slot boundary. Two interval codes bypass the schedule: one leaves only the manual button, and the other keeps the display on all the time.

A debounced manual button requests power at once and drops the request when it is released. The button and the schedule are ORed together. The button never moves or cancels a scheduled window. The power outputs come up in stages. The high-voltage enable rises first and the logic enable follows a fixed number of clock cycles later. On the way down the logic enable falls first and the high-voltage enable follows after the same delay.

Top module: `display_scheduler`

## Requirements
- R1: While reset is asserted, and after it is released with no demand present, `hv_en` and `lv_en` are both low.
- R2: The seconds count runs from 0 to 3599. A tick advances it by one and wraps it from 3599 to 0. A load with `time_value` below 3600 overwrites it and takes priority over a tick in the same cycle, and that tick is dropped. A load with `time_value` of 3600 or more is ignored.
- R3: Interval codes 1 to 14 select slot lengths of 45, 60, 90, 120, 180, 240, 300, 360, 600, 720, 900, 1200, 1800 and 3600 seconds. Slot boundaries fall at whole multiples of the slot length from second 0.
- R4: For codes 1 to 14 with duration d, the display is requested when (seconds + d) mod slot < 2d. The window therefore covers the d seconds before each boundary and the d seconds from the boundary onward, including the window that spans the wrap at second 0. A duration of 0 gives no window.
- R5: The schedule decision changes only on a tick that is not overridden by a load. A new count value or a new interval or duration code has no effect on the outputs until the next such tick.
- R6: Interval code 0 gives no scheduled request, so only the button powers the display. Interval code 15 requests power continuously from the next tick.
- R7: The button requests power while it is held. Its use does not change any later scheduled window. When the button and the schedule overlap, power stays on until both requests have ended.
- R8: When a request appears with the outputs off, `hv_en` rises on the next clock edge and `lv_en` rises STAGE_CYCLES clock edges after that. `lv_en` is never high while `hv_en` is low.
- R9: When the request ends with both outputs on, `lv_en` falls on the next edge and `hv_en` falls STAGE_CYCLES edges later. If the request returns during that wait, `hv_en` stays high and `lv_en` rises STAGE_CYCLES edges after the edge that sees the request again.
- R10: If the request ends while the block is still waiting to raise `lv_en`, `hv_en` falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| time_load | input | 1 | Strobe that writes `time_value` into the seconds count |
| time_value | input | 12 | Seconds within the hour to load |
| interval_sel | input | 4 | Interval code: 0 manual only, 1 to 14 slot length, 15 always on |
| duration_sel | input | 4 | Window half-width in seconds |
| manual_on | input | 1 | Debounced button, high while pressed |
| hv_en | output | 1 | High-voltage supply enable, raised first |
| lv_en | output | 1 | Logic supply enable, raised second |

## Verification
The hardest case to reach from the ports is a scheduled window that opens after the button has been used, together with a button press that overlaps a window. A real hour of ticks would take far too long to run. The bench instead loads the count to one second before the point of interest and then gives one tick, so each window edge, the window that spans the wrap and every slot length can be reached in a few cycles. The same load-then-tick approach separates a load or code change on its own, which must leave the outputs unchanged, from the tick that makes it take effect.

// File: rtl/display_scheduler.sv
module display_scheduler #(
  parameter int STAGE_CYCLES = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        time_load,
  input  logic [11:0] time_value,
  input  logic [3:0]  interval_sel,
  input  logic [3:0]  duration_sel,
  input  logic        manual_on,
  output logic        hv_en,
  output logic        lv_en
);

  localparam int CW = (STAGE_CYCLES > 1) ? $clog2(STAGE_CYCLES) : 1;
  localparam logic [11:0] LAST_SEC = 12'd3599;
  localparam logic [CW-1:0] STAGE_END = CW'(STAGE_CYCLES - 1);

  typedef enum logic [1:0] {PWR_OFF, PWR_RAMP, PWR_ON, PWR_DRAIN} pwr_t;

  logic [11:0]   sec;
  logic [11:0]   sec_adv;
  logic          load_ok;
  logic          auto_on;
  logic          demand;
  pwr_t          state;
  logic [CW-1:0] cnt;

  function automatic logic in_window(input logic [11:0] s, input logic [3:0] code,
                                     input logic [3:0] dur);
    logic [12:0] sum, r, lim;
    sum = {1'b0, s} + {9'd0, dur};
    lim = {8'd0, dur, 1'b0};
    case (code)
      4'h1: r = sum % 13'd45;
      4'h2: r = sum % 13'd60;
      4'h3: r = sum % 13'd90;
      4'h4: r = sum % 13'd120;
      4'h5: r = sum % 13'd180;
      4'h6: r = sum % 13'd240;
      4'h7: r = sum % 13'd300;
      4'h8: r = sum % 13'd360;
      4'h9: r = sum % 13'd600;
      4'hA: r = sum % 13'd720;
      4'hB: r = sum % 13'd900;
      4'hC: r = sum % 13'd1200;
      4'hD: r = sum % 13'd1800;
      4'hE: r = sum % 13'd3600;
      default: r = '1;
    endcase
    if (code == 4'hF) return 1'b1;
    return r < lim;
  endfunction

  assign load_ok = time_load && (time_value <= LAST_SEC);
  assign sec_adv = (sec == LAST_SEC) ? 12'd0 : sec + 12'd1;
  assign demand  = manual_on || auto_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec     <= 12'd0;
      auto_on <= 1'b0;
    end else if (load_ok) begin
      sec <= time_value;
    end else if (tick_1hz) begin
      sec     <= sec_adv;
      auto_on <= in_window(sec_adv, interval_sel, duration_sel);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PWR_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        PWR_OFF:
          if (demand) begin
            state <= PWR_RAMP;
            cnt   <= '0;
          end
        PWR_RAMP:
          if (!demand)              state <= PWR_OFF;
          else if (cnt == STAGE_END) state <= PWR_ON;
          else                      cnt   <= cnt + 1'b1;
        PWR_ON:
          if (!demand) begin
            state <= PWR_DRAIN;
            cnt   <= '0;
          end
        PWR_DRAIN:
          if (demand) begin
            state <= PWR_RAMP;
            cnt   <= '0;
          end else if (cnt == STAGE_END) state <= PWR_OFF;
          else                          cnt   <= cnt + 1'b1;
        default: state <= PWR_OFF;
      endcase
    end
  end

  assign hv_en = (state != PWR_OFF);
  assign lv_en = (state == PWR_ON);

  a_r8_lv_needs_hv: assert property (@(posedge clk) disable iff (!rst_n)
    lv_en |-> hv_en);
  a_r8_lv_after_hv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lv_en) |-> $past(hv_en));
  a_r9_hv_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en) |-> !$past(lv_en));
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec <= LAST_SEC);
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !load_ok) |=> sec == (($past(sec) == LAST_SEC) ? 12'd0 : $past(sec) + 12'd1));
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> sec == $past(time_value));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz || load_ok) |=> $stable(auto_on));
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en && !lv_en && !demand && state == PWR_RAMP) |=> !hv_en);

endmodule

// File: tb/test_display_scheduler.sv
module test_display_scheduler;
  localparam int S = 8;
  localparam int SETTLE = 2 * S + 4;

  logic clk = 0, rst_n = 0, tick_1hz = 0, time_load = 0, manual_on = 0;
  logic [11:0] time_value = '0;
  logic [3:0] interval_sel = '0, duration_sel = '0;
  logic hv_en, lv_en;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  display_scheduler #(.STAGE_CYCLES(S)) i_display_scheduler (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .time_load(time_load),
    .time_value(time_value), .interval_sel(interval_sel), .duration_sel(duration_sel),
    .manual_on(manual_on), .hv_en(hv_en), .lv_en(lv_en));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  iv;
    logic [3:0]  du;
    logic [11:0] s;
    logic        on;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{4'hC, 4'd5, 12'd1195, 1'b1}, '{4'hC, 4'd5, 12'd1194, 1'b0},
    '{4'hC, 4'd5, 12'd1204, 1'b1}, '{4'hC, 4'd5, 12'd1205, 1'b0},
    '{4'hE, 4'd5, 12'd3595, 1'b1}, '{4'hE, 4'd5, 12'd4,    1'b1},
    '{4'hE, 4'd5, 12'd5,    1'b0}, '{4'hE, 4'd5, 12'd0,    1'b1},
    '{4'h1, 4'd3, 12'd45,   1'b1}, '{4'h1, 4'd3, 12'd48,   1'b0},
    '{4'h1, 4'd3, 12'd42,   1'b1}, '{4'h3, 4'd10, 12'd80,  1'b1},
    '{4'h3, 4'd10, 12'd79,  1'b0}, '{4'h9, 4'd7, 12'd1793, 1'b1},
    '{4'h9, 4'd7, 12'd1806, 1'b1}, '{4'h9, 4'd7, 12'd1807, 1'b0},
    '{4'hA, 4'd15, 12'd705, 1'b1}, '{4'hA, 4'd15, 12'd704, 1'b0},
    '{4'h7, 4'd0, 12'd300,  1'b0}, '{4'h2, 4'd1, 12'd60,   1'b1},
    '{4'h2, 4'd1, 12'd59,   1'b1}, '{4'h2, 4'd1, 12'd61,   1'b0},
    '{4'h0, 4'd5, 12'd1200, 1'b0}, '{4'hF, 4'd0, 12'd1000, 1'b1},
    '{4'hD, 4'd2, 12'd1798, 1'b1}, '{4'h4, 4'd4, 12'd236,  1'b1},
    '{4'h5, 4'd6, 12'd174,  1'b1}, '{4'h6, 4'd9, 12'd231,  1'b1},
    '{4'h8, 4'd12, 12'd348, 1'b1}, '{4'hB, 4'd8, 12'd892,  1'b1},
    '{4'hB, 4'd8, 12'd891,  1'b0}
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hv,lv} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick();
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
  endtask

  task automatic do_load(input logic [11:0] v);
    time_load = 1; time_value = v; @(negedge clk); time_load = 0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    wait_n(3);
    check("R1 in reset", {hv_en, lv_en}, 2'b00);
    rst_n = 1;
    wait_n(4);
    check("R1 after reset", {hv_en, lv_en}, 2'b00);

    // R3 R4 R6 vector table; the E,5,0 entry also wraps the count (R2)
    for (int k = 0; k < NV; k++) begin
      interval_sel = VEC[k].iv; duration_sel = VEC[k].du;
      do_load(VEC[k].s == 12'd0 ? 12'd3599 : VEC[k].s - 12'd1);
      do_tick();
      wait_n(SETTLE);
      check((VEC[k].iv == 4'h0 || VEC[k].iv == 4'hF) ? "R6 vector" : "R3 R4 vector",
            {hv_en, lv_en}, {VEC[k].on, VEC[k].on});
    end

    interval_sel = 4'h0; do_tick(); wait_n(SETTLE);
    check("R6 code 0 idle", {hv_en, lv_en}, 2'b00);

    // R8 power-up staging
    manual_on = 1; wait_n(1);
    check("R8 hv first", {hv_en, lv_en}, 2'b10);
    wait_n(S - 1);
    check("R8 lv still low", {hv_en, lv_en}, 2'b10);
    wait_n(1);
    check("R8 lv up", {hv_en, lv_en}, 2'b11);
    // R9 power-down staging
    manual_on = 0; wait_n(1);
    check("R9 lv first down", {hv_en, lv_en}, 2'b10);
    wait_n(S - 1);
    check("R9 hv held", {hv_en, lv_en}, 2'b10);
    wait_n(1);
    check("R9 hv down", {hv_en, lv_en}, 2'b00);
    // R10 abort during ramp
    manual_on = 1; wait_n(2); manual_on = 0; wait_n(1);
    check("R10 abort ramp", {hv_en, lv_en}, 2'b00);
    // R9 request returns during drain
    manual_on = 1; wait_n(SETTLE); manual_on = 0; wait_n(2);
    manual_on = 1; wait_n(1);
    check("R9 return hv kept", {hv_en, lv_en}, 2'b10);
    wait_n(S - 1);
    check("R9 return lv waits", {hv_en, lv_en}, 2'b10);
    wait_n(1);
    check("R9 return lv up", {hv_en, lv_en}, 2'b11);
    manual_on = 0; wait_n(SETTLE);

    // R7 press does not disturb the schedule
    interval_sel = 4'hC; duration_sel = 4'd5;
    do_load(12'd1229); do_tick(); wait_n(SETTLE);
    check("R7 before press", {hv_en, lv_en}, 2'b00);
    manual_on = 1; wait_n(SETTLE);
    check("R7 pressed", {hv_en, lv_en}, 2'b11);
    manual_on = 0; wait_n(SETTLE);
    check("R7 released", {hv_en, lv_en}, 2'b00);
    do_load(12'd1193); do_tick(); wait_n(SETTLE);
    check("R7 before window", {hv_en, lv_en}, 2'b00);
    do_tick(); wait_n(SETTLE);
    check("R7 window kept", {hv_en, lv_en}, 2'b11);
    manual_on = 1; wait_n(3); manual_on = 0; wait_n(SETTLE);
    check("R7 overlap release", {hv_en, lv_en}, 2'b11);
    manual_on = 1; do_load(12'd1208); do_tick(); wait_n(SETTLE);
    check("R7 manual outlasts window", {hv_en, lv_en}, 2'b11);
    manual_on = 0; wait_n(SETTLE);
    check("R7 both ended", {hv_en, lv_en}, 2'b00);

    // R5 load and code change wait for a tick
    do_load(12'd1099); do_tick(); wait_n(SETTLE);
    do_load(12'd1200); wait_n(SETTLE);
    check("R5 load without tick", {hv_en, lv_en}, 2'b00);
    do_tick(); wait_n(SETTLE);
    check("R5 tick after load", {hv_en, lv_en}, 2'b11);
    interval_sel = 4'h5; wait_n(SETTLE);
    check("R5 code change held", {hv_en, lv_en}, 2'b11);
    do_tick(); wait_n(SETTLE);
    check("R5 code change applied", {hv_en, lv_en}, 2'b00);

    // R2 load wins over a simultaneous tick
    interval_sel = 4'hC;
    do_load(12'd1099); do_tick(); wait_n(SETTLE);
    tick_1hz = 1; time_load = 1; time_value = 12'd1203; @(negedge clk);
    tick_1hz = 0; time_load = 0; wait_n(SETTLE);
    check("R2 tick dropped with load", {hv_en, lv_en}, 2'b00);
    do_tick(); wait_n(SETTLE);
    check("R2 load kept value", {hv_en, lv_en}, 2'b11);
    // R2 out-of-range load ignored
    interval_sel = 4'hE;
    do_load(12'd3594); do_tick(); wait_n(SETTLE);
    check("R2 setup", {hv_en, lv_en}, 2'b11);
    do_load(12'd4000); do_tick(); wait_n(SETTLE);
    check("R2 bad load ignored", {hv_en, lv_en}, 2'b11);

    finished = 1;
    report();
  end
endmodule